// File: doc/BRIEF.md
# Eight-Channel DMA Priority Arbiter

This block picks which of eight DMA channel requests is served next. A 2-bit mode input chooses one of three priority schemes. The first is a plain ascending order. The second is a fixed order that interleaves the lower and upper halves of the channel set. The third rotates priority among channels 0 to 3 only, based on which of those channels last finished a transfer. In that mode channels 4 to 7 always rank below the lower four.

The grant is combinational. For the current request vector it gives a valid flag and the index of the winning channel in the same cycle. The only stored state is the rotation start point and the last mode seen. A one-cycle transfer-end strobe, with the number of the channel that just finished, moves the rotation start. Any change of the mode input resets that start point. Masking of channels that are not eligible is done by the requester before the vector arrives here.

Top module: `arbTop`

## Requirements
- R1: With prioMode = 00, priority is channel 0 highest, then 1, 2, … up to 7 lowest.
- R2: With prioMode = 01, priority from highest to lowest is 0, 4, 1, 5, 2, 6, 3, 7.
- R3: prioMode = 11 grants exactly as prioMode = 00.
- R4: With prioMode = 10, a transfer-end strobe for channel n (0 to 3) makes the lower group rank n+1, n+2, … (wrapping from 3 to 0), so that n is lowest of the four. This order takes effect from the next cycle.
- R5: With prioMode = 10, a transfer-end strobe for any channel from 4 to 7 leaves the rotation order unchanged.
- R6: With prioMode = 10, any request among channels 0 to 3 beats every request among channels 4 to 7. The upper four rank among themselves in ascending order.
- R7: In the cycle where prioMode differs from its value at the previous clock edge, the rotation restarts at ascending order 0,1,2,3. A transfer-end strobe in that cycle is ignored.
- R8: After reset the rotation order is ascending, and with no request gntValid is 0.
- R9: When reqVec is all zero, gntValid is 0 and gntChan is 0. The rotation state is kept as it was.
- R10: gntValid and gntChan follow reqVec and prioMode in the same cycle, with no register between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqVec | input | 8 | One request bit per channel, bit i for channel i |
| prioMode | input | 2 | 00 ascending, 01 interleaved, 10 rotating lower group, 11 same as 00 |
| endStb | input | 1 | One-cycle pulse: a transfer has just ended |
| endChan | input | 3 | Number of the channel that ended, valid with endStb |
| gntValid | output | 1 | High when some channel is granted |
| gntChan | output | 3 | Index of the granted channel, 0 when nothing is granted |

## Verification
The grant outputs are combinational, so the bench checks them 1 ns after it drives reqVec or prioMode, in the same cycle and well away from any clock edge. A transfer-end strobe only takes effect at the rising edge that captures it. The bench therefore holds the strobe across exactly one edge, removes it at the following falling edge, and checks the new order in that next cycle. For a mode change, the bench checks the restarted order in the cycle of the change itself, then again after the edge, to show that a strobe given in that cycle was dropped.

// File: rtl/arbPkg.sv
package arbPkg;
  localparam int CH_NUM  = 8;
  localparam int CH_W    = $clog2(CH_NUM);
  localparam int LOW_NUM = CH_NUM / 2;
  localparam int LOW_W   = $clog2(LOW_NUM);

  typedef enum logic [1:0] {
    ORD_ASC   = 2'b00,
    ORD_INTLV = 2'b01,
    ORD_ROT   = 2'b10
  } orderSel_e;

  typedef struct packed {
    orderSel_e          orderSel;
    logic [LOW_W-1:0]   rotStart;
  } ctrlStrobe_t;
endpackage

// File: rtl/arbCtrl.sv
module arbCtrl
  import arbPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        prioMode,
  input  logic              endStb,
  input  logic [CH_W-1:0]   endChan,
  output ctrlStrobe_t       strb
);
  logic [1:0]       modeQ;
  logic [LOW_W-1:0] rotQ;
  logic             modeChg;
  logic             rotMode;
  logic             lowEnd;

  assign modeChg = (prioMode != modeQ);
  assign rotMode = (prioMode == 2'b10);
  assign lowEnd  = endStb && (int'(endChan) < LOW_NUM);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= 2'b00;
      rotQ  <= '0;
    end else begin
      modeQ <= prioMode;
      if (modeChg)
        rotQ <= '0;
      else if (rotMode && lowEnd)
        rotQ <= endChan[LOW_W-1:0] + LOW_W'(1);
    end
  end

  always_comb begin
    case (prioMode)
      2'b01:   strb.orderSel = ORD_INTLV;
      2'b10:   strb.orderSel = ORD_ROT;
      default: strb.orderSel = ORD_ASC;
    endcase
    strb.rotStart = modeChg ? '0 : rotQ;
  end
endmodule

// File: rtl/arbPick.sv
module arbPick
  import arbPkg::*;
(
  input  ctrlStrobe_t        strb,
  input  logic [CH_NUM-1:0]  reqVec,
  output logic               gntValid,
  output logic [CH_W-1:0]    gntChan
);
  logic [LOW_W-1:0] rotOff [LOW_NUM];
  logic [CH_W-1:0]  slot   [CH_NUM];

  for (genvar g = 0; g < LOW_NUM; g++) begin : g_rot
    assign rotOff[g] = strb.rotStart + LOW_W'(g);
  end

  always_comb begin
    for (int p = 0; p < CH_NUM; p++) begin
      case (strb.orderSel)
        ORD_INTLV: slot[p] = (p % 2 == 1) ? CH_W'(LOW_NUM + p / 2) : CH_W'(p / 2);
        ORD_ROT:   slot[p] = (p < LOW_NUM) ? CH_W'(rotOff[p % LOW_NUM]) : CH_W'(p);
        default:   slot[p] = CH_W'(p);
      endcase
    end
  end

  always_comb begin
    gntValid = 1'b0;
    gntChan  = '0;
    for (int p = CH_NUM - 1; p >= 0; p--) begin
      if (reqVec[slot[p]]) begin
        gntValid = 1'b1;
        gntChan  = slot[p];
      end
    end
  end
endmodule

// File: rtl/arbTop.sv
module arbTop
  import arbPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CH_NUM-1:0] reqVec,
  input  logic [1:0]        prioMode,
  input  logic              endStb,
  input  logic [CH_W-1:0]   endChan,
  output logic              gntValid,
  output logic [CH_W-1:0]   gntChan
);
  ctrlStrobe_t strb;

  arbCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .prioMode (prioMode),
    .endStb   (endStb),
    .endChan  (endChan),
    .strb     (strb)
  );

  arbPick uPick (
    .strb     (strb),
    .reqVec   (reqVec),
    .gntValid (gntValid),
    .gntChan  (gntChan)
  );
endmodule

// File: rtl/arbChk.sv
module arbChk
  import arbPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [CH_NUM-1:0] reqVec,
  input logic [1:0]        prioMode,
  input logic              endStb,
  input logic [CH_W-1:0]   endChan,
  input logic              gntValid,
  input logic [CH_W-1:0]   gntChan
);
  logic [CH_NUM-1:0] belowMask;
  assign belowMask = (CH_NUM'(1) << gntChan) - CH_NUM'(1);

  AST_GRANT_IS_REQUESTED: assert property (@(posedge clk) disable iff (!rstN)
    gntValid |-> reqVec[gntChan]); // R10
  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    (reqVec == '0) |-> (!gntValid && gntChan == '0)); // R9
  AST_ASC_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (gntValid && prioMode[0] == prioMode[1]) |-> ((reqVec & belowMask) == '0)); // R1
  AST_FIXED_CH0_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (prioMode != 2'b10 && reqVec[0]) |-> (gntChan == '0)); // R2
  AST_RR_LOWER_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (prioMode == 2'b10 && reqVec[LOW_NUM-1:0] != '0) |-> (int'(gntChan) < LOW_NUM)); // R6
  AST_RR_UPPER_ASC: assert property (@(posedge clk) disable iff (!rstN)
    (prioMode == 2'b10 && reqVec[LOW_NUM-1:0] == '0 && gntValid) |-> ((reqVec & belowMask) == '0)); // R6
  AST_MODE_CHANGE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (prioMode != $past(prioMode) && prioMode == 2'b10 && reqVec[0]) |-> (gntChan == '0)); // R7
endmodule

bind arbTop arbChk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .reqVec   (reqVec),
  .prioMode (prioMode),
  .endStb   (endStb),
  .endChan  (endChan),
  .gntValid (gntValid),
  .gntChan  (gntChan)
);

// File: tb/sim_arbTop.sv
module sim_arbTop;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] reqVec = '0;
  logic [1:0] prioMode = 2'b00;
  logic       endStb = 1'b0;
  logic [2:0] endChan = '0;
  logic       gntValid;
  logic [2:0] gntChan;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  arbTop u0 (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .prioMode(prioMode),
    .endStb(endStb), .endChan(endChan), .gntValid(gntValid), .gntChan(gntChan)
  );

  task automatic expect_gnt(input string req, input logic v, input logic [2:0] c);
    nChecks++;
    if (gntValid !== v || gntChan !== c) begin
      nFails++;
      $display("FAIL %s: got valid=%0b chan=%0d, expected valid=%0b chan=%0d",
               req, gntValid, gntChan, v, c);
    end
  endtask

  // drive at a falling edge, look 1 ns later
  task automatic apply(input logic [7:0] r, input string req, input logic v, input logic [2:0] c);
    @(negedge clk);
    reqVec = r;
    #1;
    expect_gnt(req, v, c);
  endtask

  task automatic pulse_end(input logic [2:0] ch);
    @(negedge clk);
    endStb = 1'b1; endChan = ch;
    @(negedge clk);
    endStb = 1'b0;
  endtask

  task automatic test_reset;
    #1;
    expect_gnt("R8 in reset", 1'b0, 3'd0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    #1;
    expect_gnt("R9 idle after reset", 1'b0, 3'd0);
  endtask

  task automatic test_ascending;
    prioMode = 2'b00;
    apply(8'hFF, "R1 all", 1'b1, 3'd0);
    apply(8'h30, "R1 4,5", 1'b1, 3'd4);
    apply(8'h0A, "R1 1,3", 1'b1, 3'd1);
    apply(8'h80, "R1 7 only", 1'b1, 3'd7);
  endtask

  task automatic test_interleaved;
    @(negedge clk); prioMode = 2'b01;
    apply(8'h32, "R2 1,4,5", 1'b1, 3'd4);
    apply(8'h48, "R2 3,6", 1'b1, 3'd6);
    apply(8'h88, "R2 3,7", 1'b1, 3'd3);
    apply(8'h24, "R2 2,5", 1'b1, 3'd5);
  endtask

  task automatic test_mode11;
    @(negedge clk); prioMode = 2'b11;
    apply(8'h12, "R3 1,4", 1'b1, 3'd1);
    apply(8'hC4, "R3 2,6,7", 1'b1, 3'd2);
  endtask

  task automatic test_rotate;
    @(negedge clk); prioMode = 2'b10;
    apply(8'h0F, "R8 rr start", 1'b1, 3'd0);
    pulse_end(3'd1);
    apply(8'h0F, "R4 after 1", 1'b1, 3'd2);
    apply(8'h03, "R4 after 1 wrap", 1'b1, 3'd0);
    pulse_end(3'd3);
    apply(8'h0F, "R4 after 3", 1'b1, 3'd0);
    pulse_end(3'd2);
    apply(8'h09, "R4 after 2", 1'b1, 3'd3);
    pulse_end(3'd5);
    apply(8'h09, "R5 end on 5", 1'b1, 3'd3);
    apply(8'h90, "R6 upper asc", 1'b1, 3'd4);
    apply(8'h91, "R6 lower beats upper", 1'b1, 3'd0);
    apply(8'h00, "R9 no request", 1'b0, 3'd0);
    apply(8'h00, "R9 no request held", 1'b0, 3'd0);
    apply(8'h09, "R9 state kept", 1'b1, 3'd3);
  endtask

  task automatic test_mode_change;
    @(negedge clk); prioMode = 2'b00;
    @(negedge clk);
    prioMode = 2'b10; reqVec = 8'h0F; endStb = 1'b1; endChan = 3'd1;
    #1;
    expect_gnt("R7 change cycle", 1'b1, 3'd0);
    @(negedge clk);
    endStb = 1'b0;
    #1;
    expect_gnt("R7 end ignored", 1'b1, 3'd0);
    prioMode = 2'b10;
    apply(8'h0C, "R10 same cycle", 1'b1, 3'd2);
  endtask

  initial begin
    test_reset();
    test_ascending();
    test_interleaved();
    test_mode11();
    test_rotate();
    test_mode_change();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule